// File: doc/BRIEF.md
# Packet-Based OTP Read Controller

This block sits between a simple register read/write port and a synchronous one-time-programmable array whose contents form a chain of variable-length packets. Each packet is one header word followed by its payload. Software places a word address in the mode register and sets the go bit of the control register. The controller starts at address 0 and walks the chain of headers until it finds the packet whose address range contains the requested word. It then copies that packet's header and payload into holding storage. A busy flag in the status register stays high for the whole transfer.

Once the flag drops, software reads the header from its own register. It loads a payload index (normally zero) and reads the data register repeatedly, and each read returns the next payload word. A request that falls past the end of the chain sets an error flag in place of loading a packet. Software sees no direct mapping from array word addresses to data: any address inside a packet returns that whole packet.

Top module: `otp_pkt_reader`

## Requirements
- R1: After reset, the status, header, payload index and payload data registers all read as zero.
- R2: The registers sit at these byte offsets: control 0x00 (bit 6 = go), mode 0x04 (bits 31:16 = target word address, all 32 bits read back as written), payload index 0x08 (bits 8:0), status 0x0C (bit 6 = busy, bit 0 = error), header 0x20, payload data 0x24. Unmapped offsets read zero.
- R3: An accepted go sets busy from the next clock. Busy stays high for exactly 2 cycles per header visited plus 2 cycles per payload word of the loaded packet, or 2 cycles per header visited when the walk ends in error. It then clears.
- R4: Bits 15:8 of a header hold the size s. The payload is s+1 words, and the next header is s+2 words after this one. A target anywhere in [start of packet k, start of packet k+1) loads packet k.
- R5: A header with size 0 ends the chain. A target beyond it finishes with error = 1, a header register of 0, and payload data reads of 0.
- R6: After a successful load, the header register holds the full header word of the selected packet.
- R7: A payload data read returns payload word [index] and advances the index by one. The index saturates at 0x1FF.
- R8: A payload data read with index greater than s returns zero.
- R9: The payload index register can be written and read back. An accepted go clears it to 0.
- R10: A go written while busy is ignored: the request in progress and its target are unchanged.
- R11: An accepted go clears the error flag and the previously loaded packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of reg_rd |
| rom_en | output | 1 | Array read enable |
| rom_addr | output | AW (12) | Array word address |
| rom_data | input | 32 | Array read data, one cycle after rom_en |

## Verification
Register reads are combinational, so each read value is sampled shortly after the falling edge of the cycle in which the read strobe is driven. The payload index moves at the rising edge that closes a data read. The busy flag is first due at the falling edge after the rising edge that takes the go write. The reference model computes from the array image how many cycles busy then lasts: two per header visited, plus two per payload word. It polls the status register on every cycle of that window and one cycle past it. The header, error flag and every payload word, including one read past the end, are compared only once the model's busy window has closed.

// File: rtl/otp_pkt_pkg.sv
package otp_pkt_pkg;
  localparam int DATA_W = 32;
  localparam int TGT_W  = 16;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_MODE = 8'h04;
  localparam logic [7:0] OFS_PIDX = 8'h08;
  localparam logic [7:0] OFS_STAT = 8'h0C;
  localparam logic [7:0] OFS_HDR  = 8'h20;
  localparam logic [7:0] OFS_DATA = 8'h24;

  localparam int GO_BIT   = 6;
  localparam int BUSY_BIT = 6;
  localparam int ERR_BIT  = 0;
  localparam int TGT_LSB  = 16;
  localparam int SIZE_LSB = 8;

  typedef enum logic [2:0] {
    WK_IDLE,
    WK_HDR_RD,
    WK_HDR_EV,
    WK_PAY_RD,
    WK_PAY_WR
  } walk_st_e;
endpackage

// File: rtl/otp_pkt_regs.sv
module otp_pkt_regs
  import otp_pkt_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic              err,
  input  logic [DATA_W-1:0] hdr,
  input  logic [DATA_W-1:0] pay_word,
  input  logic [IDX_W-1:0]  pidx,
  output logic              start_cmd,
  output logic              idx_wr,
  output logic [IDX_W-1:0]  idx_wdata,
  output logic              dr_read,
  output logic [TGT_W-1:0]  tgt
);
  logic [DATA_W-1:0] mode_q, mode_d;
  logic              mode_en;

  assign mode_en   = reg_wr && (reg_addr == OFS_MODE);
  assign start_cmd = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[GO_BIT];
  assign idx_wr    = reg_wr && (reg_addr == OFS_PIDX);
  assign idx_wdata = reg_wdata[IDX_W-1:0];
  assign dr_read   = reg_rd && (reg_addr == OFS_DATA);
  assign tgt       = mode_q[TGT_LSB +: TGT_W];

  always_comb begin
    mode_d = mode_q;
    if (mode_en) mode_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        OFS_CTRL: reg_rdata[GO_BIT] = busy;
        OFS_MODE: reg_rdata = mode_q;
        OFS_PIDX: reg_rdata[IDX_W-1:0] = pidx;
        OFS_STAT: begin
          reg_rdata[BUSY_BIT] = busy;
          reg_rdata[ERR_BIT]  = err;
        end
        OFS_HDR:  reg_rdata = hdr;
        OFS_DATA: reg_rdata = pay_word;
        default:  reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/otp_pkt_walker.sv
module otp_pkt_walker
  import otp_pkt_pkg::*;
#(
  parameter int DEPTH  = 2816,
  parameter int AW     = 12,
  parameter int SIZE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_cmd,
  input  logic [TGT_W-1:0]  tgt_in,
  input  logic [DATA_W-1:0] rom_data,
  output logic              rom_en,
  output logic [AW-1:0]     rom_addr,
  output logic              busy,
  output logic              start_acc,
  output logic              err,
  output logic              pkt_valid,
  output logic [DATA_W-1:0] hdr,
  output logic [SIZE_W-1:0] pkt_size,
  output logic              buf_we,
  output logic [SIZE_W-1:0] buf_waddr,
  output logic [DATA_W-1:0] buf_wdata
);
  localparam int PW = ((AW > TGT_W) ? AW : TGT_W) + 2;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  walk_st_e          st_q, st_d;
  logic [PW-1:0]     ptr_q, ptr_d;
  logic [TGT_W-1:0]  tgt_q, tgt_d;
  logic [SIZE_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] hdr_q, hdr_d;
  logic              err_q, err_d;
  logic              vld_q, vld_d;
  logic              oob_q, oob_d;

  logic [SIZE_W-1:0] rd_size;
  logic [PW-1:0]     span_end;
  logic [PW-1:0]     pay_addr;
  logic              hdr_oob;
  logic              pay_oob;

  assign rd_size  = rom_data[SIZE_LSB +: SIZE_W];
  assign span_end = ptr_q + PW'(rd_size) + PW'(2);
  assign pay_addr = ptr_q + PW'(1) + PW'(cnt_q);
  assign hdr_oob  = (ptr_q >= DEPTH_P);
  assign pay_oob  = (pay_addr >= DEPTH_P);

  assign busy      = (st_q != WK_IDLE);
  assign start_acc = start_cmd && (st_q == WK_IDLE);
  assign err       = err_q;
  assign pkt_valid = vld_q;
  assign hdr       = hdr_q;
  assign pkt_size  = hdr_q[SIZE_LSB +: SIZE_W];
  assign buf_waddr = cnt_q;
  assign buf_we    = (st_q == WK_PAY_WR);
  assign buf_wdata = oob_q ? '0 : rom_data;

  assign rom_en   = ((st_q == WK_HDR_RD) && !hdr_oob) ||
                    ((st_q == WK_PAY_RD) && !pay_oob);
  assign rom_addr = (st_q == WK_PAY_RD) ? pay_addr[AW-1:0] : ptr_q[AW-1:0];

  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    tgt_d = tgt_q;
    cnt_d = cnt_q;
    hdr_d = hdr_q;
    err_d = err_q;
    vld_d = vld_q;
    oob_d = oob_q;
    case (st_q)
      WK_IDLE: begin
        if (start_cmd) begin
          st_d  = WK_HDR_RD;
          ptr_d = '0;
          tgt_d = tgt_in;
          cnt_d = '0;
          hdr_d = '0;
          err_d = 1'b0;
          vld_d = 1'b0;
        end
      end
      WK_HDR_RD: begin
        if (hdr_oob) begin
          st_d  = WK_IDLE;
          err_d = 1'b1;
        end else begin
          st_d = WK_HDR_EV;
        end
      end
      WK_HDR_EV: begin
        if (rd_size == '0) begin
          st_d  = WK_IDLE;
          err_d = 1'b1;
        end else if (PW'(tgt_q) < span_end) begin
          st_d  = WK_PAY_RD;
          hdr_d = rom_data;
          cnt_d = '0;
        end else begin
          st_d  = WK_HDR_RD;
          ptr_d = span_end;
        end
      end
      WK_PAY_RD: begin
        st_d  = WK_PAY_WR;
        oob_d = pay_oob;
      end
      WK_PAY_WR: begin
        if (cnt_q == pkt_size) begin
          st_d  = WK_IDLE;
          vld_d = 1'b1;
        end else begin
          st_d  = WK_PAY_RD;
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WK_IDLE;
      ptr_q <= '0;
      tgt_q <= '0;
      cnt_q <= '0;
      hdr_q <= '0;
      err_q <= 1'b0;
      vld_q <= 1'b0;
      oob_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
      tgt_q <= tgt_d;
      cnt_q <= cnt_d;
      hdr_q <= hdr_d;
      err_q <= err_d;
      vld_q <= vld_d;
      oob_q <= oob_d;
    end
  end
endmodule

// File: rtl/otp_pkt_buf.sv
module otp_pkt_buf
  import otp_pkt_pkg::*;
#(
  parameter int SIZE_W = 8,
  parameter int IDX_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SIZE_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              idx_clr,
  input  logic              idx_wr,
  input  logic [IDX_W-1:0]  idx_wdata,
  input  logic              rd_adv,
  input  logic              valid,
  input  logic [SIZE_W-1:0] size,
  output logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] rd_word
);
  localparam int ENTRIES = 1 << SIZE_W;

  logic [DATA_W-1:0] store [ENTRIES];
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              in_range;

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_comb begin
    idx_d = idx_q;
    if (idx_clr)                      idx_d = '0;
    else if (idx_wr)                  idx_d = idx_wdata;
    else if (rd_adv && (idx_q != '1)) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign in_range = valid && (idx_q <= IDX_W'(size));
  assign rd_word  = in_range ? store[idx_q[SIZE_W-1:0]] : '0;
  assign idx      = idx_q;
endmodule

// File: rtl/otp_pkt_reader.sv
module otp_pkt_reader
  import otp_pkt_pkg::*;
#(
  parameter int DEPTH  = 2816,
  parameter int SIZE_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int IDX_W = SIZE_W + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        rom_en,
  output logic [AW-1:0] rom_addr,
  input  logic [31:0] rom_data
);
  logic              busy;
  logic              start_cmd;
  logic              start_acc;
  logic              err;
  logic              pkt_valid;
  logic [DATA_W-1:0] hdr;
  logic [SIZE_W-1:0] pkt_size;
  logic              buf_we;
  logic [SIZE_W-1:0] buf_waddr;
  logic [DATA_W-1:0] buf_wdata;
  logic              idx_wr;
  logic [IDX_W-1:0]  idx_wdata;
  logic              dr_read;
  logic [IDX_W-1:0]  pidx;
  logic [DATA_W-1:0] pay_word;
  logic [TGT_W-1:0]  tgt;

  otp_pkt_regs #(.IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .err       (err),
    .hdr       (hdr),
    .pay_word  (pay_word),
    .pidx      (pidx),
    .start_cmd (start_cmd),
    .idx_wr    (idx_wr),
    .idx_wdata (idx_wdata),
    .dr_read   (dr_read),
    .tgt       (tgt)
  );

  otp_pkt_walker #(.DEPTH(DEPTH), .AW(AW), .SIZE_W(SIZE_W)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_cmd (start_cmd),
    .tgt_in    (tgt),
    .rom_data  (rom_data),
    .rom_en    (rom_en),
    .rom_addr  (rom_addr),
    .busy      (busy),
    .start_acc (start_acc),
    .err       (err),
    .pkt_valid (pkt_valid),
    .hdr       (hdr),
    .pkt_size  (pkt_size),
    .buf_we    (buf_we),
    .buf_waddr (buf_waddr),
    .buf_wdata (buf_wdata)
  );

  otp_pkt_buf #(.SIZE_W(SIZE_W), .IDX_W(IDX_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (buf_we),
    .waddr     (buf_waddr),
    .wdata     (buf_wdata),
    .idx_clr   (start_acc),
    .idx_wr    (idx_wr),
    .idx_wdata (idx_wdata),
    .rd_adv    (dr_read),
    .valid     (pkt_valid),
    .size      (pkt_size),
    .idx       (pidx),
    .rd_word   (pay_word)
  );
endmodule

// File: rtl/otp_pkt_reader_chk.sv
module otp_pkt_reader_chk #(
  parameter int IDX_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             start_cmd,
  input logic             err,
  input logic             pkt_valid,
  input logic [31:0]      hdr,
  input logic             dr_read,
  input logic             idx_wr,
  input logic [IDX_W-1:0] pidx,
  input logic             rom_en
);
  // R3
  go_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && !busy) |=> (busy && !err && !pkt_valid && (hdr == 32'h0)));

  // R10
  go_while_busy_keeps_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_cmd && !idx_wr && !dr_read) |=> $stable(pidx));

  // R7
  idx_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_read && !start_cmd && !idx_wr && (pidx != '1)) |=> (pidx == $past(pidx) + 1'b1));

  // R5
  err_hdr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (hdr == 32'h0));

  // R11
  end_one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (err != pkt_valid));

  // R3
  rom_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |-> busy);
endmodule

bind otp_pkt_reader otp_pkt_reader_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .start_cmd (start_cmd),
  .err       (err),
  .pkt_valid (pkt_valid),
  .hdr       (hdr),
  .dr_read   (dr_read),
  .idx_wr    (idx_wr),
  .pidx      (pidx),
  .rom_en    (rom_en)
);

// File: tb/otp_pkt_reader_bench.sv
`timescale 1ns/1ps
module otp_pkt_reader_bench;
  localparam int DEPTH = 2816;
  localparam int AW    = 12;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_rd;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        rom_en;
  logic [AW-1:0] rom_addr;
  logic [31:0] rom_q;

  logic [31:0] rom_img [DEPTH];
  int n_chk;
  int n_fail;
  bit done;

  otp_pkt_reader u_otp_pkt_reader (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .rom_en    (rom_en),
    .rom_addr  (rom_addr),
    .rom_data  (rom_q)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rom_en) rom_q <= rom_img[int'(rom_addr)];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  function automatic logic [31:0] pay_val(input int a);
    return 32'hA500_0000 ^ (a * 32'h0001_0003);
  endfunction

  // Behavioural chain walk: cycles busy, error, packet start and size.
  task automatic model(input int tgt, output int n, output bit e, output int base, output int sz);
    int ptr;
    int s;
    ptr = 0; n = 0; e = 1'b0; base = 0; sz = 0;
    while (1) begin
      if (ptr >= DEPTH) begin n += 1; e = 1'b1; return; end
      s = int'(rom_img[ptr][15:8]);
      n += 2;
      if (s == 0) begin e = 1'b1; return; end
      if (tgt < ptr + s + 2) begin
        base = ptr; sz = s; n += 2 * (s + 1);
        return;
      end
      ptr += s + 2;
    end
  endtask

  task automatic wait_busy(input int j0, input int n);
    logic [31:0] d;
    for (int j = j0; j <= n + 1; j++) begin
      bus_rd(8'h0C, d);
      check("R3 busy per cycle", {31'h0, d[6]}, {31'h0, (j <= n)});
    end
  endtask

  task automatic verify(input int tgt);
    int n; bit e; int base; int sz;
    logic [31:0] d;
    model(tgt, n, e, base, sz);
    bus_rd(8'h0C, d);
    check("R5/R11 status after load", d, {31'h0, e});
    bus_rd(8'h20, d);
    check("R6/R5 header", d, e ? 32'h0 : rom_img[base]);
    bus_rd(8'h08, d);
    check("R9 index cleared by go", d, 32'h0);
    if (e) begin
      bus_rd(8'h24, d);
      check("R5 data after error", d, 32'h0);
    end else begin
      for (int i = 0; i <= sz + 1; i++) begin
        bus_rd(8'h24, d);
        if (i <= sz) check("R4/R7 payload word", d, pay_val(base + 1 + i));
        else         check("R8 past end", d, 32'h0);
      end
      bus_rd(8'h08, d);
      check("R7 index advanced", d, sz + 2);
    end
  endtask

  task automatic request(input int tgt);
    int n; bit e; int base; int sz;
    model(tgt, n, e, base, sz);
    bus_wr(8'h04, {tgt[15:0], 16'h0});
    bus_wr(8'h00, 32'h40);
    wait_busy(1, n);
    verify(tgt);
  endtask

  task automatic put_pkt(input int at, input int s, input int id);
    rom_img[at] = {8'hC0 + id[7:0], 8'h00, s[7:0], 8'h3C};
    for (int i = 0; i <= s; i++) rom_img[at + 1 + i] = pay_val(at + 1 + i);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    int n; bit e; int base; int sz;
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 8'h0; reg_wdata = 32'h0;
    for (int i = 0; i < DEPTH; i++) rom_img[i] = 32'h0;
    put_pkt(0, 3, 0);
    put_pkt(5, 1, 1);
    put_pkt(8, 255, 2);
    put_pkt(265, 2, 3);
    rom_img[269] = 32'hEE00_00EE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    bus_rd(8'h0C, d); check("R1 status", d, 32'h0);
    bus_rd(8'h20, d); check("R1 header", d, 32'h0);
    bus_rd(8'h08, d); check("R1 index", d, 32'h0);
    bus_rd(8'h24, d); check("R1 data", d, 32'h0);

    // R2 mode readback and unmapped offset
    bus_wr(8'h04, 32'h1234_ABCD);
    bus_rd(8'h04, d); check("R2 mode readback", d, 32'h1234_ABCD);
    bus_rd(8'h10, d); check("R2 unmapped", d, 32'h0);

    // R4 boundaries of each packet
    request(0);
    request(4);
    request(5);
    request(7);
    request(8);
    request(265);
    request(268);
    // R5 terminator and beyond
    request(269);
    request(2000);
    request(65535);
    // R11 valid request after an error
    request(6);

    // R10 go while busy is ignored
    model(5, n, e, base, sz);
    bus_wr(8'h04, {16'd5, 16'h0});
    bus_wr(8'h00, 32'h40);
    bus_wr(8'h04, {16'd0, 16'h0});
    bus_wr(8'h00, 32'h40);
    wait_busy(3, n);
    verify(5);

    // R9 index write then stream from there
    bus_wr(8'h08, 32'h1);
    bus_rd(8'h08, d); check("R9 index readback", d, 32'h1);
    bus_rd(8'h24, d); check("R9 data at index 1", d, pay_val(7));

    // R7 saturation at 0x1FF
    bus_wr(8'h08, 32'h1FF);
    bus_rd(8'h24, d); check("R8 data at max index", d, 32'h0);
    bus_rd(8'h08, d); check("R7 index saturates", d, 32'h1FF);

    done = 1'b1;
    finish_run();
  end
endmodule